// File: doc/BRIEF.md
# Enhanced Second-Chance Victim Selector

This block keeps two status bits for each of a parameterised number of page frames: a reference bit and a modify bit. It also keeps a circular next pointer. Access events set the bits. When a replacement is requested, the block walks the frames from the pointer, one frame per cycle, and picks a victim. An unused clean frame is preferred. An unused dirty frame is the next choice. Frames that were recently used are only taken once a full walk has cleared their reference bits.

The search runs in passes. Pass zero looks for a frame with reference 0 and modify 0. Every frame it passes over has its reference bit cleared. If a whole lap finds nothing, pass one looks for a frame with reference 0 and modify 1, and keeps clearing reference bits as it goes. If that lap also fails, the frames that were recently used are now unreferenced, so the search goes back to pass zero and succeeds there.

The result is the victim's index and a flag that says whether the victim must be written back. It is held until the requester acknowledges it. The pointer then stands one frame past the victim.

The controller has three states:
- `ST_IDLE` waits for a request. `req` moves it to `ST_SCAN`.
- `ST_SCAN` examines one frame per cycle. On a hit it moves to `ST_RESP`. On a miss it stays, and after each full lap it toggles the pass.
- `ST_RESP` holds the result. `resp_ack` moves it back to `ST_IDLE`.

Top module: `esc_victim_sel`

## Requirements
- R1: After reset, every reference and modify bit is 0 and the pointer is frame 0. `busy` and `resp_valid` are both low.
- R2: Each port acts on the frame it names, in the cycle it is asserted.
  - An access (`acc_valid`) sets the reference bit of frame `acc_idx`.
  - If `acc_write` is also 1, the access sets that frame's modify bit as well.
  - A load (`load_valid`) sets frame `load_idx` to reference 1, modify 0. A load takes priority over an access to the same frame in the same cycle.
- R3: Pass zero starts at the pointer. The first frame found with reference 0 and modify 0 is the victim. Each frame examined before it has its reference bit cleared.
- R4: If a full lap of pass zero finds no victim, pass one continues in the same circular order. The first frame with reference 0 and modify 1 is the victim, and reference bits are still cleared on the frames passed over.
- R5: If pass one also completes a lap without a victim, the search returns to pass zero. The first frame that was formerly reference 1, modify 0 is then the victim.
- R6: `resp_dirty` equals the victim's modify bit, so 1 means the frame must be written back before reuse.
- R7: After a victim is reported, the pointer stands at the victim index plus one, modulo the frame count. The next search starts there.
- R8: The frame search takes one cycle per frame examined. `resp_valid` is high in the cycle after the edge at which the k-th frame is examined, where k is the number of frames examined.
- R9: While `resp_valid` is high and `resp_ack` is low, `resp_idx` and `resp_dirty` hold their values. `req` is ignored and `busy` stays low. `resp_ack` returns the block to idle.
- R10: A search examines at most 2N+1 frames, where N is the number of frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access event for frame `acc_idx` |
| acc_idx | input | IW | Frame that was accessed |
| acc_write | input | 1 | The access was a write |
| load_valid | input | 1 | A new page was loaded into frame `load_idx` |
| load_idx | input | IW | Frame that received the new page |
| req | input | 1 | Request a victim (sampled only when idle) |
| busy | output | 1 | A search is in progress |
| resp_valid | output | 1 | A victim is being reported |
| resp_idx | output | IW | Victim frame index |
| resp_dirty | output | 1 | The victim needs a page-out |
| resp_ack | input | 1 | The requester accepts the response |

## Verification
A four-frame configuration is driven through all 256 combinations of per-frame events: nothing, a read, a write or a load. A victim search follows each combination, and the bit state carries over from one round to the next. Across the rounds, victims are found in the first pass, in the second pass and after the demotion restart. Each search is compared with a bench model on three things:
- The index tells apart the class priority and the circular order starting from the moved pointer.
- The dirty flag tells apart clean and modified victims.
- The cycle count shows whether the examined-frame count, including the clearing of reference bits, is right.

Some rounds also hold the response while `req` is asserted, to show that the response stays stable and that no new search starts.

// File: rtl/esc_pkg.sv
package esc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_RESP = 2'd2
    } esc_state_t;
endpackage

// File: rtl/esc_frame_store.sv
// Per-frame reference/modify storage with access, load and scan-clear updates.
module esc_frame_store #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [IW-1:0] acc_idx,
    input  logic          acc_write,
    input  logic          load_valid,
    input  logic [IW-1:0] load_idx,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  ref_bits,
    output logic [N-1:0]  mod_bits
);
    for (genvar i = 0; i < N; i++) begin : g_frame
        logic r_q, m_q, r_d, m_d;
        logic acc_hit, load_hit, clr_hit;

        assign acc_hit  = acc_valid  && (acc_idx  == IW'(i));
        assign load_hit = load_valid && (load_idx == IW'(i));
        assign clr_hit  = clr_en     && (clr_idx  == IW'(i));

        always_comb begin
            r_d = r_q;
            m_d = m_q;
            if (clr_hit) r_d = 1'b0;
            if (acc_hit) begin
                r_d = 1'b1;
                if (acc_write) m_d = 1'b1;
            end
            if (load_hit) begin
                r_d = 1'b1;
                m_d = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= 1'b0;
                m_q <= 1'b0;
            end else begin
                r_q <= r_d;
                m_q <= m_d;
            end
        end

        assign ref_bits[i] = r_q;
        assign mod_bits[i] = m_q;
    end
endmodule

// File: rtl/esc_scan_ctrl.sv
// Multi-pass scan controller: pointer, pass/lap tracking and response hold.
module esc_scan_ctrl
    import esc_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          resp_ack,
    input  logic [N-1:0]  ref_bits,
    input  logic [N-1:0]  mod_bits,
    output logic          clr_en,
    output logic [IW-1:0] clr_idx,
    output logic          busy,
    output logic          resp_valid,
    output logic [IW-1:0] resp_idx,
    output logic          resp_dirty
);
    esc_state_t    state_q, state_d;
    logic [IW-1:0] ptr_q, ptr_inc, step_q, idx_q;
    logic          pass_q, dirty_q, cur_ref, cur_mod, hit, lap_end;

    assign cur_ref = ref_bits[ptr_q];
    assign cur_mod = mod_bits[ptr_q];
    // pass 0 accepts class 00, pass 1 accepts class 01
    assign hit     = !cur_ref && (cur_mod == pass_q);
    assign lap_end = (step_q == IW'(N - 1));
    assign ptr_inc = (ptr_q == IW'(N - 1)) ? '0 : ptr_q + 1'b1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)      state_d = ST_SCAN;
            ST_SCAN: if (hit)      state_d = ST_RESP;
            ST_RESP: if (resp_ack) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            step_q  <= '0;
            pass_q  <= 1'b0;
            idx_q   <= '0;
            dirty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    step_q <= '0;
                    pass_q <= 1'b0;
                end
                ST_SCAN: begin
                    ptr_q <= ptr_inc;
                    if (hit) begin
                        idx_q   <= ptr_q;
                        dirty_q <= cur_mod;
                    end else if (lap_end) begin
                        step_q <= '0;
                        pass_q <= !pass_q;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy       = (state_q == ST_SCAN);
        resp_valid = (state_q == ST_RESP);
        resp_idx   = idx_q;
        resp_dirty = dirty_q;
        clr_en     = (state_q == ST_SCAN) && !hit;
        clr_idx    = ptr_q;
    end
endmodule

// File: rtl/esc_victim_sel.sv
// Enhanced second-chance victim selector top.
module esc_victim_sel #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [IW-1:0] acc_idx,
    input  logic          acc_write,
    input  logic          load_valid,
    input  logic [IW-1:0] load_idx,
    input  logic          req,
    output logic          busy,
    output logic          resp_valid,
    output logic [IW-1:0] resp_idx,
    output logic          resp_dirty,
    input  logic          resp_ack
);
    logic [N-1:0]  ref_bits, mod_bits;
    logic          clr_en;
    logic [IW-1:0] clr_idx;

    esc_frame_store #(.N(N)) u_store (
        .clk, .rst_n, .acc_valid, .acc_idx, .acc_write,
        .load_valid, .load_idx, .clr_en, .clr_idx,
        .ref_bits, .mod_bits
    );

    esc_scan_ctrl #(.N(N)) u_ctrl (
        .clk, .rst_n, .req, .resp_ack, .ref_bits, .mod_bits,
        .clr_en, .clr_idx, .busy, .resp_valid, .resp_idx, .resp_dirty
    );
endmodule

// File: rtl/esc_victim_sel_chk.sv
module esc_victim_sel_chk #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic [IW-1:0] acc_idx,
    input logic          acc_write,
    input logic          load_valid,
    input logic [IW-1:0] load_idx,
    input logic          busy,
    input logic          resp_valid,
    input logic [IW-1:0] resp_idx,
    input logic          resp_dirty,
    input logic          resp_ack,
    input logic [N-1:0]  ref_bits,
    input logic [N-1:0]  mod_bits
);
    logic [IW+2:0] scan_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) scan_cnt <= '0;
        else                 scan_cnt <= scan_cnt + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !busy && !resp_valid && (ref_bits == '0) && (mod_bits == '0));

    // R2
    access_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> ref_bits[$past(acc_idx)]);

    // R2
    write_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && !(load_valid && load_idx == acc_idx)
        |=> mod_bits[$past(acc_idx)]);

    // R2
    load_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> ref_bits[$past(load_idx)] && !mod_bits[$past(load_idx)]);

    // R8
    resp_from_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> $past(busy));

    // R9
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_ack
        |=> resp_valid && !busy && $stable(resp_idx) && $stable(resp_dirty));

    // R10
    scan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(scan_cnt) <= 2 * N));
endmodule

bind esc_victim_sel esc_victim_sel_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .acc_write(acc_write), .load_valid(load_valid), .load_idx(load_idx),
    .busy(busy), .resp_valid(resp_valid), .resp_idx(resp_idx),
    .resp_dirty(resp_dirty), .resp_ack(resp_ack),
    .ref_bits(ref_bits), .mod_bits(mod_bits)
);

// File: tb/esc_victim_sel_bench.sv
module esc_victim_sel_bench;
    localparam int N  = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0, load_valid = 1'b0, req = 1'b0, resp_ack = 1'b0;
    logic [IW-1:0] acc_idx = '0, load_idx = '0;
    logic busy, resp_valid, resp_dirty;
    logic [IW-1:0] resp_idx;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit mref [N];
    bit mmod [N];
    int mptr;

    always #10 clk = ~clk;

    esc_victim_sel #(.N(N)) u_esc_victim_sel (
        .clk, .rst_n, .acc_valid, .acc_idx, .acc_write, .load_valid, .load_idx,
        .req, .busy, .resp_valid, .resp_idx, .resp_dirty, .resp_ack
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    // op: 1 read access, 2 write access, 3 load
    task automatic apply_op(input int f, input int op);
        @(negedge clk);
        acc_valid  = (op == 1 || op == 2);
        acc_write  = (op == 2);
        acc_idx    = IW'(f);
        load_valid = (op == 3);
        load_idx   = IW'(f);
        @(posedge clk);
        if (op != 0) mref[f] = 1'b1;
        if (op == 2) mmod[f] = 1'b1;
        if (op == 3) mmod[f] = 1'b0;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; load_valid = 1'b0;
    endtask

    task automatic do_scan(input bit hold, input bit first);
        int exams = 0, pass = 0, step = 0, vic = 0, laps = 0, cnt = 0;
        bit vdirty = 1'b0, got = 1'b0;
        string tag;
        // reference search over the model
        while (1) begin
            int f = mptr;
            exams++;
            if (!mref[f] && (mmod[f] == (pass == 1))) begin
                vic = f; vdirty = mmod[f];
                mptr = (mptr + 1) % N;
                break;
            end
            mref[f] = 1'b0;
            mptr = (mptr + 1) % N;
            step++;
            if (step == N) begin step = 0; pass ^= 1; laps++; end
        end
        tag = first ? "R1" : (laps == 0) ? "R3" : (laps == 1) ? "R4" : "R5";

        @(negedge clk); req = 1'b1;
        @(posedge clk);
        @(negedge clk); req = 1'b0;
        while (cnt < 40) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (resp_valid) begin got = 1'b1; break; end
        end
        chk(got, "R10", int'(got), 1);
        chk(cnt == exams, "R8", cnt, exams);
        // R7: index also depends on the pointer left by the previous search
        chk(int'(resp_idx) == vic, tag, int'(resp_idx), vic);
        chk(resp_dirty == vdirty, "R6", int'(resp_dirty), int'(vdirty));
        if (hold) begin
            req = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            req = 1'b0;
            chk(resp_valid && !busy, "R9", int'(busy), 0);
            chk(int'(resp_idx) == vic, "R9", int'(resp_idx), vic);
        end
        resp_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        resp_ack = 1'b0;
        chk(!resp_valid && !busy, "R9", int'(resp_valid), 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin mref[i] = 1'b0; mmod[i] = 1'b0; end
        mptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(!busy, "R1", int'(busy), 0);
        chk(!resp_valid, "R1", int'(resp_valid), 0);
        do_scan(1'b1, 1'b1);
        // R2 exercised through every per-frame event combination
        for (int it = 0; it < 256; it++) begin
            for (int f = 0; f < N; f++) apply_op(f, (it >> (2 * f)) & 3);
            do_scan(it % 8 == 0, 1'b0);
        end
        finish_run();
    end
endmodule